// File: doc/BRIEF.md
# Performance Counter Bank with Operation Counters

The block holds eight 48-bit counters, numbered 0 to 7, that a processor core uses to measure its own behaviour. Each counter has an 8-bit selector. Most selector codes make the counter add a per-cycle increment taken from the core's event vector. One code counts load/store instructions, and it may run only on the upper counters. A group of operation codes works differently. A counter in operation mode takes no raw event. It looks at the per-cycle activity of other counters, chosen through a mapping register. It then counts cycles that pass a run-length threshold, counts cycles where two counters are active together, or records the shortest or the longest run of active cycles.

Software programs the bank through a single-cycle register port, which is also used to read it back. Every write takes effect on the next clock edge. Each counter keeps a sticky overflow flag that is set when the counter wraps. Writing 1 to a flag clears it.

Each counter has its own mode register, driven by an enumerated state machine with these states: IDLE, EVENT, LDST_INST, LDST_UOP, THRESH, BOTH, RUN_MIN and RUN_MAX. The mode changes only when the counter's selector is written. That write is the single transition, from any state to the state that the written code decodes to for that counter's index. Reset puts every counter in IDLE.

Top module: `pmu_bank`

## Requirements
- R1: After reset, all counters, selectors, the mapping register, the thresholds and the overflow flags read as zero, and every counter is idle.
- R2: A selector code from 1 to NUM_EV (default 16) makes the counter add ev_inc[code-1] in each cycle.
- R3: Code 0x9B counts load/store work only on counters 5, 6 and 7. Counter 7 adds ldst_insts, where a fused pair counts 2. Counters 5 and 6 add ldst_uops, where a fused pair counts 1. On counters 0 to 4 the code leaves the counter unchanged.
- R4: The activity of a counter in a cycle is its raw increment in EVENT or load/store mode, and zero in every other mode. For counter k from 2 to 7, the mapping field at bits [3(k-2)+2 : 3(k-2)] names the counter whose activity is input A. For counters 2, 4 and 6, input B is the activity of counter k+1.
- R5: Code 0xF1 on counter 2, 4 or 6 adds 1 in each cycle where input A is non-zero and the current run of non-zero cycles, this cycle included, is at least the counter's threshold. A threshold of 0 or 1 counts every active cycle.
- R6: Code 0xF2 on counter 2, 4 or 6 adds 1 in each cycle where both input A and input B are non-zero.
- R7: Code 0xF9 on counters 2 to 7 works as follows. When a run of active cycles on input A ends, the counter takes the run length if it holds 0 or holds a larger value.
- R8: Code 0xFA on counters 2 to 7 works as follows. When a run ends, the counter takes the run length if that is greater than the value it holds.
- R9: Several codes leave the counter unchanged. These are 0x00, codes above NUM_EV other than the defined ones, 0xF3 to 0xF8, 0xFB to 0xFF, 0xF1 and 0xF2 on counters other than 2, 4 and 6, and 0xF9 and 0xFA on counters 0 and 1.
- R10: A counter that carries out of bit 47 sets its sticky flag, held at bit k of register 0x14. Writing 1 to a bit clears that flag. Writing 0 leaves it set. A new wrap in the same cycle as a clear wins.
- R11: A write lands on the next clock edge. A counter written in a cycle ignores that cycle's increment and sets no flag. Writing a selector restarts that counter's run tracking.
- R12: The register map is as follows. Addresses 0x00 to 0x07 hold the counters. 0x08 to 0x0F hold the selectors, which read back as written. 0x10 is the mapping register, 18 bits wide. 0x11, 0x12 and 0x13 are the 16-bit thresholds of counters 2, 4 and 6. 0x14 holds the flags. Other addresses read 0, and writes to them do nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 5 | Register address for the read and the write |
| wdata | input | 48 | Write data |
| rdata | output | 48 | Read data of the register at addr (combinational) |
| ev_inc | input | 16x2 | Per-cycle increment of each raw event |
| ldst_insts | input | 2 | Load/store instructions this cycle, fused pairs counting 2 |
| ldst_uops | input | 2 | Load/store issue slots this cycle, fused pairs counting 1 |

## Verification
The risky coincidences are a register write landing in the same cycle as counting activity. Examples are a counter write against its own increment, a flag clear against a fresh wrap, and a selector write against the end of a run. The bench provokes these by writing at random while the events keep running. It also preloads counters close to all ones under a constant increment. A cycle-accurate model in the bench predicts the result: the written value wins over the increment, the wrap wins over the clear, and the run restarts from zero.

// File: rtl/pmu_pkg.sv
package pmu_pkg;

    localparam int NPMC    = 8;
    localparam int SEL_W   = 8;
    localparam int MAP_FW  = 3;
    localparam int MAP_W   = MAP_FW * (NPMC - 2);
    localparam int NTHR    = 3;

    localparam logic [SEL_W-1:0] SEL_LDST = 8'h9B;
    localparam logic [SEL_W-1:0] SEL_THR  = 8'hF1;
    localparam logic [SEL_W-1:0] SEL_AND  = 8'hF2;
    localparam logic [SEL_W-1:0] SEL_MIN  = 8'hF9;
    localparam logic [SEL_W-1:0] SEL_MAX  = 8'hFA;

    localparam logic [4:0] A_SEL0 = 5'h08;
    localparam logic [4:0] A_MAP  = 5'h10;
    localparam logic [4:0] A_THR0 = 5'h11;
    localparam logic [4:0] A_OVF  = 5'h14;

    typedef enum logic [2:0] {
        M_IDLE, M_EVENT, M_LDST_INST, M_LDST_UOP,
        M_THRESH, M_BOTH, M_RUN_MIN, M_RUN_MAX
    } pmc_mode_e;

    // Selector code to mode, honouring what each counter index may do.
    function automatic pmc_mode_e decode_sel(logic [SEL_W-1:0] code, int idx, int nev);
        logic paired;
        logic mapped;
        paired = (idx == 2) || (idx == 4) || (idx == 6);
        mapped = (idx >= 2);
        if (code >= 8'd1 && int'(code) <= nev) return M_EVENT;
        if (code == SEL_LDST) begin
            if (idx == 7) return M_LDST_INST;
            if (idx == 5 || idx == 6) return M_LDST_UOP;
            return M_IDLE;
        end
        if (code == SEL_THR) return paired ? M_THRESH : M_IDLE;
        if (code == SEL_AND) return paired ? M_BOTH : M_IDLE;
        if (code == SEL_MIN) return mapped ? M_RUN_MIN : M_IDLE;
        if (code == SEL_MAX) return mapped ? M_RUN_MAX : M_IDLE;
        return M_IDLE;
    endfunction

endpackage

// File: rtl/pmu_run_unit.sv
module pmu_run_unit #(
    parameter int RUN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             act,
    output logic [RUN_W-1:0] run_q,
    output logic [RUN_W:0]   len,
    output logic             run_end
);

    always_ff @(posedge clk) begin
        if (!rst_n)
            run_q <= '0;
        else if (clr)
            run_q <= '0;
        else if (act)
            run_q <= (run_q == '1) ? run_q : run_q + 1'b1;
        else
            run_q <= '0;
    end

    assign len     = {1'b0, run_q} + 1'b1;
    assign run_end = !act && (run_q != '0);

endmodule

// File: rtl/pmu_counter.sv
module pmu_counter
    import pmu_pkg::*;
#(
    parameter int IDX    = 0,
    parameter int CNT_W  = 48,
    parameter int NUM_EV = 16,
    parameter int INC_W  = 2,
    parameter int RUN_W  = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         sel_we,
    input  logic                         val_we,
    input  logic [CNT_W-1:0]             wdata,
    input  logic [NUM_EV-1:0][INC_W-1:0] ev_inc,
    input  logic [1:0]                   ldst_insts,
    input  logic [1:0]                   ldst_uops,
    input  logic                         op_a,
    input  logic                         op_b,
    input  logic [RUN_W-1:0]             thr,
    output logic [CNT_W-1:0]             value,
    output logic [SEL_W-1:0]             sel_q,
    output logic [INC_W-1:0]             raw_inc,
    output logic                         wrap
);

    localparam int EV_IW = (NUM_EV > 1) ? $clog2(NUM_EV) : 1;

    pmc_mode_e          mode_q;
    logic [INC_W-1:0]   inc;
    logic               take_run;
    logic [CNT_W:0]     sum;
    logic [RUN_W-1:0]   run_q;
    logic [RUN_W:0]     len;
    logic               run_end;
    logic [CNT_W-1:0]   run_ext;
    logic [EV_IW-1:0]   ev_idx;

    // State register: the mode follows a selector write only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= M_IDLE;
            sel_q  <= '0;
        end else if (sel_we) begin
            mode_q <= decode_sel(wdata[SEL_W-1:0], IDX, NUM_EV);
            sel_q  <= wdata[SEL_W-1:0];
        end
    end

    generate
        if (IDX >= 2) begin : g_run
            pmu_run_unit #(.RUN_W(RUN_W)) u_run (
                .clk     (clk),
                .rst_n   (rst_n),
                .clr     (sel_we),
                .act     (op_a),
                .run_q   (run_q),
                .len     (len),
                .run_end (run_end)
            );
        end else begin : g_norun
            assign run_q   = '0;
            assign len     = '0;
            assign run_end = 1'b0;
        end
    endgenerate

    assign run_ext = {{(CNT_W-RUN_W){1'b0}}, run_q};
    assign ev_idx  = EV_IW'(sel_q - 8'd1);

    // Output process: increment and run capture per mode.
    always_comb begin
        inc      = '0;
        raw_inc  = '0;
        take_run = 1'b0;
        unique case (mode_q)
            M_IDLE:      ;
            M_EVENT: begin
                inc     = ev_inc[ev_idx];
                raw_inc = inc;
            end
            M_LDST_INST: begin
                inc     = INC_W'(ldst_insts);
                raw_inc = inc;
            end
            M_LDST_UOP: begin
                inc     = INC_W'(ldst_uops);
                raw_inc = inc;
            end
            M_THRESH:    inc = INC_W'(op_a && (len >= {1'b0, thr}));
            M_BOTH:      inc = INC_W'(op_a && op_b);
            M_RUN_MIN:   take_run = run_end && ((value == '0) || (run_ext < value));
            M_RUN_MAX:   take_run = run_end && (run_ext > value);
            default:     ;
        endcase
    end

    assign sum  = {1'b0, value} + {{(CNT_W+1-INC_W){1'b0}}, inc};
    assign wrap = !val_we && sum[CNT_W];

    always_ff @(posedge clk) begin
        if (!rst_n)
            value <= '0;
        else if (val_we)
            value <= wdata;
        else if (take_run)
            value <= run_ext;
        else
            value <= sum[CNT_W-1:0];
    end

endmodule

// File: rtl/pmu_bank.sv
module pmu_bank
    import pmu_pkg::*;
#(
    parameter int CNT_W  = 48,
    parameter int NUM_EV = 16,
    parameter int INC_W  = 2,
    parameter int RUN_W  = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [4:0]                   addr,
    input  logic [CNT_W-1:0]             wdata,
    output logic [CNT_W-1:0]             rdata,
    input  logic [NUM_EV-1:0][INC_W-1:0] ev_inc,
    input  logic [1:0]                   ldst_insts,
    input  logic [1:0]                   ldst_uops
);

    logic [NPMC-1:0][CNT_W-1:0] cnt_val;
    logic [NPMC-1:0][SEL_W-1:0] sel_val;
    logic [NPMC-1:0][INC_W-1:0] raw_inc;
    logic [NPMC-1:0]            wrap_vec;
    logic [NPMC-1:0]            ovf_q;
    logic [MAP_W-1:0]           map_q;
    logic [NTHR-1:0][RUN_W-1:0] thr_q;
    logic [NPMC-1:0]            ovf_clr;

    genvar k;
    generate
        for (k = 0; k < NPMC; k++) begin : g_pmc
            logic             op_a;
            logic             op_b;
            logic [RUN_W-1:0] thr;
            if (k >= 2) begin : g_a
                assign op_a = |raw_inc[map_q[MAP_FW*(k-2) +: MAP_FW]];
            end else begin : g_na
                assign op_a = 1'b0;
            end
            if (k >= 2 && (k % 2) == 0) begin : g_pair
                assign op_b = |raw_inc[k+1];
                assign thr  = thr_q[(k-2)/2];
            end else begin : g_npair
                assign op_b = 1'b0;
                assign thr  = '0;
            end
            pmu_counter #(
                .IDX(k), .CNT_W(CNT_W), .NUM_EV(NUM_EV), .INC_W(INC_W), .RUN_W(RUN_W)
            ) u_cnt (
                .clk        (clk),
                .rst_n      (rst_n),
                .sel_we     (wr_en && (addr == A_SEL0 + 5'(k))),
                .val_we     (wr_en && (addr == 5'(k))),
                .wdata      (wdata),
                .ev_inc     (ev_inc),
                .ldst_insts (ldst_insts),
                .ldst_uops  (ldst_uops),
                .op_a       (op_a),
                .op_b       (op_b),
                .thr        (thr),
                .value      (cnt_val[k]),
                .sel_q      (sel_val[k]),
                .raw_inc    (raw_inc[k]),
                .wrap       (wrap_vec[k])
            );
        end
    endgenerate

    assign ovf_clr = (wr_en && addr == A_OVF) ? wdata[NPMC-1:0] : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            map_q <= '0;
            thr_q <= '0;
            ovf_q <= '0;
        end else begin
            ovf_q <= (ovf_q & ~ovf_clr) | wrap_vec;
            if (wr_en && addr == A_MAP)
                map_q <= wdata[MAP_W-1:0];
            for (int j = 0; j < NTHR; j++)
                if (wr_en && addr == A_THR0 + 5'(j))
                    thr_q[j] <= wdata[RUN_W-1:0];
        end
    end

    always_comb begin
        rdata = '0;
        if (addr < A_SEL0)
            rdata = cnt_val[addr[2:0]];
        else if (addr < A_MAP)
            rdata = {{(CNT_W-SEL_W){1'b0}}, sel_val[addr[2:0]]};
        else if (addr == A_MAP)
            rdata = {{(CNT_W-MAP_W){1'b0}}, map_q};
        else if (addr >= A_THR0 && addr < A_THR0 + 5'(NTHR))
            rdata = {{(CNT_W-RUN_W){1'b0}}, thr_q[addr - A_THR0]};
        else if (addr == A_OVF)
            rdata = {{(CNT_W-NPMC){1'b0}}, ovf_q};
    end

endmodule

// File: rtl/pmu_bank_chk.sv
module pmu_bank_chk #(
    parameter int CNT_W = 48
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  wr_en,
    input logic [4:0]            addr,
    input logic [CNT_W-1:0]      wdata,
    input logic [7:0][CNT_W-1:0] cnt,
    input logic [7:0][7:0]       sel,
    input logic [7:0]            ovf
);

    genvar k;
    generate
        for (k = 0; k < 8; k++) begin : g_k
            AST_CNT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_en && addr == 5'(k)) |=> (cnt[k] == $past(wdata))); // R11
            AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
                (ovf[k] && !(wr_en && addr == 5'h14 && wdata[k])) |=> ovf[k]); // R10
        end
    endgenerate

    AST_LOW_LDST_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (sel[0] == 8'h9B && !(wr_en && addr == 5'd0)) |=> $stable(cnt[0])); // R3
    AST_ODD_THR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (sel[3] == 8'hF1 && !(wr_en && addr == 5'd3)) |=> $stable(cnt[3])); // R9
    AST_AND_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (sel[4] == 8'hF2 && !(wr_en && addr == 5'd4))
        |=> (CNT_W'(cnt[4] - $past(cnt[4])) <= CNT_W'(1))); // R6
    AST_MAX_NO_SHRINK: assert property (@(posedge clk) disable iff (!rst_n)
        (sel[5] == 8'hFA && !(wr_en && addr == 5'd5)) |=> (cnt[5] >= $past(cnt[5]))); // R8

endmodule

bind pmu_bank pmu_bank_chk #(.CNT_W(CNT_W)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (wr_en),
    .addr  (addr),
    .wdata (wdata),
    .cnt   (cnt_val),
    .sel   (sel_val),
    .ovf   (ovf_q)
);

// File: tb/pmu_bank_tb.sv
module pmu_bank_tb;

    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic             wr_en = 1'b0;
    logic [4:0]       addr = '0;
    logic [47:0]      wdata = '0;
    logic [47:0]      rdata;
    logic [15:0][1:0] ev = '0;
    logic [1:0]       li = '0;
    logic [1:0]       lu = '0;

    pmu_bank u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .ev_inc(ev), .ldst_insts(li), .ldst_uops(lu)
    );

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [47:0] m_cnt [8];
    logic [7:0]  m_sel [8];
    logic [15:0] m_run [8];
    logic [17:0] m_map;
    logic [15:0] m_thr [3];
    logic [7:0]  m_ovf;

    // 0 idle, 1 event, 2 ldst inst, 3 ldst uop, 4 thresh, 5 both, 6 min, 7 max
    function automatic int mode_of(logic [7:0] s, int k);
        if (s >= 8'd1 && s <= 8'd16) return 1;
        if (s == 8'h9B) return (k == 7) ? 2 : ((k == 5 || k == 6) ? 3 : 0);
        if (s == 8'hF1) return (k == 2 || k == 4 || k == 6) ? 4 : 0;
        if (s == 8'hF2) return (k == 2 || k == 4 || k == 6) ? 5 : 0;
        if (s == 8'hF9) return (k >= 2) ? 6 : 0;
        if (s == 8'hFA) return (k >= 2) ? 7 : 0;
        return 0;
    endfunction

    function automatic logic [47:0] exp_reg(logic [4:0] a);
        if (a < 5'h08) return m_cnt[a[2:0]];
        if (a < 5'h10) return {40'd0, m_sel[a[2:0]]};
        if (a == 5'h10) return {30'd0, m_map};
        if (a >= 5'h11 && a <= 5'h13) return {32'd0, m_thr[a - 5'h11]};
        if (a == 5'h14) return {40'd0, m_ovf};
        return 48'd0;
    endfunction

    task automatic tick();
        logic [1:0]  act [8];
        logic [47:0] n_cnt [8];
        logic [15:0] n_run [8];
        logic [7:0]  n_sel [8];
        logic [15:0] n_thr [3];
        logic [17:0] n_map;
        logic [7:0]  wraps;
        logic [7:0]  clr;
        wraps = '0;
        for (int k = 0; k < 8; k++) begin
            int md;
            md = mode_of(m_sel[k], k);
            act[k] = (md == 1) ? ev[int'(m_sel[k]) - 1] : (md == 2) ? li : (md == 3) ? lu : 2'd0;
        end
        for (int k = 0; k < 8; k++) begin
            int md;
            logic a, b;
            logic [16:0] len;
            logic [48:0] sum;
            logic [1:0]  inc;
            logic [47:0] r;
            md = mode_of(m_sel[k], k);
            a = 1'b0; b = 1'b0; inc = '0;
            if (k >= 2) a = (act[m_map[3*(k-2) +: 3]] != 0);
            if (k >= 2 && k % 2 == 0) b = (act[k+1] != 0);
            len = {1'b0, m_run[k]} + 17'd1;
            case (md)
                1, 2, 3: inc = act[k];
                4: inc = (a && len >= {1'b0, m_thr[(k-2)/2]}) ? 2'd1 : 2'd0;
                5: inc = (a && b) ? 2'd1 : 2'd0;
                default: inc = '0;
            endcase
            sum = {1'b0, m_cnt[k]} + {47'd0, inc};
            n_cnt[k] = sum[47:0];
            wraps[k] = sum[48];
            r = {32'd0, m_run[k]};
            if (k >= 2 && !a && m_run[k] != 0) begin
                if (md == 6 && (m_cnt[k] == 0 || r < m_cnt[k])) n_cnt[k] = r;
                if (md == 7 && r > m_cnt[k]) n_cnt[k] = r;
            end
            n_run[k] = (k >= 2 && a) ? ((m_run[k] == 16'hFFFF) ? m_run[k] : m_run[k] + 16'd1) : 16'd0;
            n_sel[k] = m_sel[k];
            if (wr_en && addr == 5'(k)) begin
                n_cnt[k] = wdata;
                wraps[k] = 1'b0;
            end
            if (wr_en && addr == 5'(8 + k)) begin
                n_sel[k] = wdata[7:0];
                n_run[k] = '0;
            end
        end
        n_map = (wr_en && addr == 5'h10) ? wdata[17:0] : m_map;
        for (int j = 0; j < 3; j++)
            n_thr[j] = (wr_en && addr == 5'(17 + j)) ? wdata[15:0] : m_thr[j];
        clr = (wr_en && addr == 5'h14) ? wdata[7:0] : 8'd0;
        @(posedge clk);
        for (int k = 0; k < 8; k++) begin
            m_cnt[k] = n_cnt[k];
            m_run[k] = n_run[k];
            m_sel[k] = n_sel[k];
        end
        for (int j = 0; j < 3; j++) m_thr[j] = n_thr[j];
        m_map = n_map;
        m_ovf = (m_ovf & ~clr) | wraps;
        @(negedge clk);
    endtask

    task automatic wr(logic [4:0] a, logic [47:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic check_reg(logic [4:0] a, string tag);
        logic [47:0] e;
        addr = a; wr_en = 1'b0;
        #1;
        e = exp_reg(a);
        checks++;
        if (rdata !== e) begin
            errors++;
            $display("FAIL %s addr %0h actual %0h expected %0h", tag, a, rdata, e);
        end
        tick();
    endtask

    task automatic rand_inputs(int dens);
        for (int e = 0; e < 16; e++)
            ev[e] = (($urandom % 100) < dens) ? 2'($urandom % 4) : 2'd0;
        li = 2'($urandom % 3);
        lu = (li == 0) ? 2'd0 : (li == 2) ? 2'(1 + $urandom % 2) : 2'd1;
    endtask

    task automatic run_rand(int n, int dens);
        for (int i = 0; i < n; i++) begin
            rand_inputs(dens);
            tick();
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            errors++;
            $display("FAIL R1 watchdog: actual hung, expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic on0, on1;
        void'($urandom(32'hC0FFEE));
        for (int k = 0; k < 8; k++) begin
            m_cnt[k] = '0; m_sel[k] = '0; m_run[k] = '0;
        end
        for (int j = 0; j < 3; j++) m_thr[j] = '0;
        m_map = '0; m_ovf = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: everything clear, events running yet idle counters hold
        rand_inputs(80);
        for (int a = 0; a < 21; a++) check_reg(5'(a), "R1");

        // R2 / R12: raw events on every counter, selector readback
        for (int k = 0; k < 8; k++) wr(5'(8 + k), 48'(1 + $urandom % 16));
        run_rand(200, 60);
        for (int k = 0; k < 8; k++) check_reg(5'(k), "R2");
        for (int k = 0; k < 8; k++) check_reg(5'(8 + k), "R12");
        check_reg(5'h1A, "R12");

        // R3: load/store code on all counters
        for (int k = 0; k < 8; k++) wr(5'(8 + k), 48'h9B);
        for (int k = 0; k < 8; k++) wr(5'(k), 48'd0);
        run_rand(150, 50);
        for (int k = 0; k < 8; k++) check_reg(5'(k), "R3");

        // R5 / R6: threshold and AND counters
        wr(5'h08, 48'd3); wr(5'h09, 48'd5); wr(5'h0B, 48'd7);
        wr(5'h0D, 48'd2); wr(5'h0F, 48'd4);
        wr(5'h0A, 48'hF1); wr(5'h0C, 48'hF2); wr(5'h0E, 48'hF1);
        wr(5'h10, 48'((1 << 6) | (3 << 12)));
        wr(5'h11, 48'd3); wr(5'h13, 48'd0);
        for (int k = 0; k < 8; k++) wr(5'(k), 48'd0);
        run_rand(300, 55);
        check_reg(5'd2, "R5"); check_reg(5'd6, "R5"); check_reg(5'd4, "R6");
        check_reg(5'h10, "R12"); check_reg(5'h11, "R12");

        // R7 / R8: run min and max with bursty inputs
        wr(5'h08, 48'd1); wr(5'h09, 48'd2);
        wr(5'h0A, 48'hF9); wr(5'h0B, 48'hFA); wr(5'h0C, 48'hF9); wr(5'h0D, 48'hFA);
        wr(5'h10, 48'((1 << 6) | (1 << 9)));
        for (int k = 0; k < 8; k++) wr(5'(k), 48'd0);
        on0 = 1'b0; on1 = 1'b0;
        for (int i = 0; i < 400; i++) begin
            if ($urandom % 100 < 20) on0 = ~on0;
            if ($urandom % 100 < 30) on1 = ~on1;
            ev = '0;
            ev[0] = on0 ? 2'(1 + $urandom % 3) : 2'd0;
            ev[1] = on1 ? 2'(1 + $urandom % 3) : 2'd0;
            tick();
        end
        ev = '0;
        tick(); tick();
        check_reg(5'd2, "R7"); check_reg(5'd4, "R7");
        check_reg(5'd3, "R8"); check_reg(5'd5, "R8");

        // R9: unsupported codes stay idle with preloaded values
        wr(5'h0B, 48'hF1); wr(5'h0D, 48'hF2); wr(5'h08, 48'hF9); wr(5'h09, 48'hFA);
        wr(5'h0A, 48'hF5); wr(5'h0C, 48'h00); wr(5'h0E, 48'h80); wr(5'h0F, 48'h11);
        wr(5'h10, 48'h0);
        for (int k = 0; k < 8; k++) wr(5'(k), 48'(1000 * (k + 1)));
        for (int i = 0; i < 30; i++) begin
            ev = '1; li = 2'd2; lu = 2'd1;
            tick();
        end
        for (int k = 0; k < 8; k++) check_reg(5'(k), "R9");

        // R10 / R11: write beats increment, wrap, sticky flag, clear
        ev = '0; ev[0] = 2'd3;
        wr(5'h08, 48'd1);
        wr(5'd0, 48'd100);
        check_reg(5'd0, "R11");
        wr(5'd0, 48'hFFFF_FFFF_FFFE);
        check_reg(5'h14, "R10");
        ev[0] = 2'd0;
        wr(5'h14, 48'd0);
        check_reg(5'h14, "R10");
        wr(5'h14, 48'hFF);
        check_reg(5'h14, "R10");
        ev[0] = 2'd3;
        wr(5'd0, 48'hFFFF_FFFF_FFFD);
        wr(5'h14, 48'h01);
        check_reg(5'h14, "R10");

        // R4 / R11 mixed: random writes while events run
        for (int i = 0; i < 3000; i++) begin
            rand_inputs(50);
            if ($urandom % 100 < 12) begin
                logic [4:0] a;
                logic [47:0] d;
                a = 5'($urandom % 32);
                d = {$urandom, $urandom};
                if (a >= 5'h08 && a < 5'h10) begin
                    case ($urandom % 7)
                        0: d = 48'h9B;
                        1: d = 48'hF1;
                        2: d = 48'hF2;
                        3: d = 48'hF9;
                        4: d = 48'hFA;
                        5: d = 48'(1 + $urandom % 16);
                        default: d = 48'($urandom % 256);
                    endcase
                end else if (a < 5'h08 && ($urandom % 2) == 1) begin
                    d = 48'hFFFF_FFFF_FFF0 | 48'($urandom % 16);
                end else if (a >= 5'h11 && a <= 5'h13) begin
                    d = 48'($urandom % 6);
                end
                wr(a, d);
            end else begin
                tick();
            end
            if (i % 40 == 39) check_reg(5'($urandom % 21), "R4");
        end
        for (int a = 0; a < 21; a++) check_reg(5'(a), "R4");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule